// File: doc/BRIEF.md
# Serial Systematic Encoder for a (7,4) Cyclic Code

This block turns a four-bit message, presented one bit per clock with the highest-order coefficient first, into a seven-bit systematic codeword of the binary cyclic code generated by g(x) = 1 + x + x^3. The codeword is sent out serially, also highest-order coefficient first. The four message bits pass through to the output unchanged. While they do, a three-stage division register builds the remainder of x^3·m(x) modulo g(x). After the last message bit, the register is unloaded onto the output as the three parity bits.

A frame opens with a start pulse while the encoder is idle. Message bits are taken only in cycles where the input valid strobe is high, so the source may leave gaps. The parity bits follow the fourth message bit on back-to-back cycles, with no gaps. A single-cycle last strobe marks the seventh output bit. A new frame can open in the same cycle in which that strobe is visible.

Top module: `cyclic_enc`

## Requirements
- R1: While reset is high, and in the first cycle after it, `dout_o`, `dout_vld_o` and `dout_last_o` are 0.
- R2: Each message bit accepted (`din_vld_i` high while a frame expects data) appears on `dout_o` in the next cycle with `dout_vld_o` high. Bits leave in the order they were accepted, so the first output bit is the coefficient of x^6.
- R3: In the three cycles right after the fourth message bit is output, `dout_vld_o` stays high. `dout_o` carries the remainder of x^3·m(x) divided by 1+x+x^3, coefficient of x^2 first, then x^1, then x^0.
- R4: Every emitted seven-bit word, read as c6..c0 in output order, is divisible by 1+x+x^3. The all-zero message yields seven zeros, and the message 1000 yields 1000101.
- R5: `dout_last_o` is high for exactly one cycle per frame, together with the seventh valid output bit, and never without `dout_vld_o`.
- R6: During the message phase, a cycle with `din_vld_i` low produces no valid output and leaves the codeword unchanged.
- R7: A start pulse during a frame, up to and including the cycle that produces the seventh bit, is ignored. A start in the cycle in which `dout_last_o` is high opens the next frame.
- R8: While idle, `din_vld_i` is ignored and nothing is output. This includes the start cycle itself, which accepts no data bit.
- R9: Each start clears the parity register, so a codeword depends only on its own message.
- R10: Each frame has exactly seven valid output bits, and `dout_vld_o` is low outside frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Opens a frame when the encoder is idle |
| din_i | input | 1 | Serial message bit |
| din_vld_i | input | 1 | Qualifies `din_i` |
| dout_o | output | 1 | Serial codeword bit (registered) |
| dout_vld_o | output | 1 | Qualifies `dout_o` |
| dout_last_o | output | 1 | Marks the seventh codeword bit |

## Verification
Two events can coincide. The last parity bit leaves while a new start arrives, and an idle data strobe can coincide with that same start. The bench raises start in the cycle before the last strobe and holds it through the last-strobe cycle. It expects the early pulse to be ignored and the later one to open exactly one new frame whose codeword is correct. In a separate case it drives a data strobe with a one bit in the start cycle and checks that this bit never reaches the codeword.

// File: rtl/cenc_pkg.sv
package cenc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MSG  = 2'd1,
    ST_PAR  = 2'd2
  } enc_state_e;
endpackage

// File: rtl/cenc_ctrl.sv
module cenc_ctrl
  import cenc_pkg::*;
#(
  parameter int K = 4,
  parameter int M = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic din_vld,
  output logic clr,
  output logic feed,
  output logic drain,
  output logic last_now,
  output logic msg_phase,
  output logic par_phase
);
  localparam int CMAX = (K > M) ? K : M;
  localparam int CW   = (CMAX > 1) ? $clog2(CMAX) : 1;

  enc_state_e     state;
  logic [CW-1:0]  cnt;

  assign msg_phase = (state == ST_MSG);
  assign par_phase = (state == ST_PAR);
  assign clr       = (state == ST_IDLE) && start;
  assign feed      = msg_phase && din_vld;
  assign drain     = par_phase;
  assign last_now  = par_phase && (cnt == CW'(M - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (start) state <= ST_MSG;
        end
        ST_MSG: begin
          if (din_vld) begin
            if (cnt == CW'(K - 1)) begin
              cnt   <= '0;
              state <= ST_PAR;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_PAR: begin
          if (cnt == CW'(M - 1)) begin
            cnt   <= '0;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state <= ST_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/cenc_divreg.sv
module cenc_divreg #(
  parameter int         M   = 3,
  parameter logic [M:0] GEN = 4'b1011
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic feed,
  input  logic drain,
  input  logic din,
  output logic par_msb
);
  logic [M-1:0] rem_q;
  logic [M-1:0] shifted;
  logic [M-1:0] fed;
  logic         fb;

  assign fb      = din ^ rem_q[M-1];
  assign par_msb = rem_q[M-1];

  for (genvar gi = 0; gi < M; gi++) begin : g_stage
    if (gi == 0) begin : g_first
      assign shifted[gi] = 1'b0;
    end else begin : g_rest
      assign shifted[gi] = rem_q[gi-1];
    end
    if (GEN[gi]) begin : g_tap
      assign fed[gi] = shifted[gi] ^ fb;
    end else begin : g_notap
      assign fed[gi] = shifted[gi];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      rem_q <= '0;
    end else if (feed) begin
      rem_q <= fed;
    end else if (drain) begin
      rem_q <= shifted;
    end
  end
endmodule

// File: rtl/cenc_outsel.sv
module cenc_outsel (
  input  logic clk,
  input  logic rst,
  input  logic feed,
  input  logic drain,
  input  logic last_now,
  input  logic din,
  input  logic par_msb,
  output logic dout,
  output logic dout_vld,
  output logic dout_last
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dout      <= 1'b0;
      dout_vld  <= 1'b0;
      dout_last <= 1'b0;
    end else begin
      dout      <= feed ? din : (drain ? par_msb : 1'b0);
      dout_vld  <= feed | drain;
      dout_last <= last_now;
    end
  end
endmodule

// File: rtl/cyclic_enc.sv
module cyclic_enc #(
  parameter int             N   = 7,
  parameter int             K   = 4,
  parameter logic [N-K:0]   GEN = 4'b1011
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic din_i,
  input  logic din_vld_i,
  output logic dout_o,
  output logic dout_vld_o,
  output logic dout_last_o
);
  localparam int M = N - K;

  logic clr, feed, drain, last_now, msg_phase, par_phase, par_msb;

  cenc_ctrl #(.K(K), .M(M)) u_ctrl (
    .clk(clk), .rst(rst), .start(start_i), .din_vld(din_vld_i),
    .clr(clr), .feed(feed), .drain(drain), .last_now(last_now),
    .msg_phase(msg_phase), .par_phase(par_phase)
  );

  cenc_divreg #(.M(M), .GEN(GEN)) u_div (
    .clk(clk), .rst(rst), .clr(clr), .feed(feed), .drain(drain),
    .din(din_i), .par_msb(par_msb)
  );

  cenc_outsel u_out (
    .clk(clk), .rst(rst), .feed(feed), .drain(drain), .last_now(last_now),
    .din(din_i), .par_msb(par_msb),
    .dout(dout_o), .dout_vld(dout_vld_o), .dout_last(dout_last_o)
  );
endmodule

// File: rtl/cenc_chk.sv
module cenc_chk #(
  parameter int N = 7
) (
  input logic clk,
  input logic rst,
  input logic din,
  input logic din_vld,
  input logic dout,
  input logic dout_vld,
  input logic dout_last,
  input logic msg_phase,
  input logic par_phase
);
  logic [7:0] vcnt;

  always_ff @(posedge clk) begin
    if (rst) vcnt <= '0;
    else if (dout_vld) vcnt <= dout_last ? 8'd0 : vcnt + 8'd1;
  end

  a_r2_echo: assert property (@(posedge clk) disable iff (rst)
    (msg_phase && din_vld) |=> (dout_vld && dout == $past(din)));
  a_r6_gap_silent: assert property (@(posedge clk) disable iff (rst)
    (msg_phase && !din_vld) |=> !dout_vld);
  a_r3_parity_valid: assert property (@(posedge clk) disable iff (rst)
    par_phase |=> dout_vld);
  a_r5_last_valid: assert property (@(posedge clk) disable iff (rst)
    dout_last |-> dout_vld);
  a_r5_last_single: assert property (@(posedge clk) disable iff (rst)
    dout_last |=> !dout_last);
  a_r10_count: assert property (@(posedge clk) disable iff (rst)
    dout_last |-> (vcnt == 8'(N - 1)));
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (!msg_phase && !par_phase) |=> !dout_vld);
endmodule

bind cyclic_enc cenc_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .din(din_i), .din_vld(din_vld_i),
  .dout(dout_o), .dout_vld(dout_vld_o), .dout_last(dout_last_o),
  .msg_phase(msg_phase), .par_phase(par_phase)
);

// File: tb/test_cyclic_enc.sv
`timescale 1ns/1ps
module test_cyclic_enc;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, din_i = 1'b0, din_vld_i = 1'b0;
  logic dout_o, dout_vld_o, dout_last_o;

  int n_chk = 0;
  int n_fail = 0;
  logic obit  [0:1023];
  logic olast [0:1023];
  int   ocnt = 0;

  always #4 clk = ~clk;

  cyclic_enc i_cyclic_enc (
    .clk(clk), .rst(rst), .start_i(start_i), .din_i(din_i),
    .din_vld_i(din_vld_i), .dout_o(dout_o), .dout_vld_o(dout_vld_o),
    .dout_last_o(dout_last_o)
  );

  always @(negedge clk) begin
    if (!rst && dout_vld_o && ocnt < 1024) begin
      obit[ocnt]  = dout_o;
      olast[ocnt] = dout_last_o;
      ocnt++;
    end
  end

  function automatic logic [2:0] rem7(input logic [6:0] w);
    logic [6:0] v = w;
    for (int i = 6; i >= 3; i--)
      if (v[i]) v = v ^ (7'b0001011 << (i - 3));
    return v[2:0];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic send_msg(input logic [3:0] m, input bit gaps);
    for (int i = 3; i >= 0; i--) begin
      if (gaps) begin
        din_vld_i = 1'b0; din_i = ~m[i]; tick();
      end
      din_vld_i = 1'b1; din_i = m[i]; tick();
    end
    din_vld_i = 1'b0; din_i = 1'b0;
  endtask

  task automatic start_frame();
    start_i = 1'b1; tick(); start_i = 1'b0;
  endtask

  task automatic check_frame(input int base, input logic [3:0] m, input string tag);
    logic [6:0] exp_cw, got;
    exp_cw = {m, rem7({m, 3'b000})};
    got = '0;
    for (int j = 0; j < 7; j++) begin
      got[6-j] = obit[base+j];
      chk(obit[base+j] == exp_cw[6-j], (j < 4) ? "R2" : "R3", obit[base+j], exp_cw[6-j]);
      chk(olast[base+j] == (j == 6), "R5", olast[base+j], (j == 6));
    end
    chk(rem7(got) == 3'b000, "R4", rem7(got), 0);
    if (tag != "") chk(got == exp_cw, tag, got, exp_cw);
  endtask

  task automatic run_frame(input logic [3:0] m, input bit gaps, input string tag);
    int base;
    #1 base = ocnt;
    start_frame();
    send_msg(m, gaps);
    repeat (6) tick();
    #1;
    chk(ocnt == base + 7, "R10", ocnt - base, 7);
    check_frame(base, m, tag);
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int base;
    repeat (3) tick();
    chk(dout_o == 0 && dout_vld_o == 0 && dout_last_o == 0, "R1",
        {dout_o, dout_vld_o, dout_last_o}, 0);
    rst = 1'b0;
    tick();
    chk(dout_o == 0 && dout_vld_o == 0 && dout_last_o == 0, "R1",
        {dout_o, dout_vld_o, dout_last_o}, 0);

    // exhaustive sweep, with gaps on some messages (R6), consecutive frames (R9)
    for (int m = 0; m < 16; m++) run_frame(4'(m), (m % 3) == 0, "");
    for (int m = 15; m >= 0; m--) run_frame(4'(m), (m % 2) == 1, "R9");

    run_frame(4'b0000, 1'b0, "R4");
    run_frame(4'b1000, 1'b1, "R4");
    #1 chk({obit[ocnt-7], obit[ocnt-6], obit[ocnt-5], obit[ocnt-4],
            obit[ocnt-3], obit[ocnt-2], obit[ocnt-1]} == 7'b1000101, "R4", 0, 7'b1000101);

    // R8: idle data strobes ignored
    #1 base = ocnt;
    din_vld_i = 1'b1; din_i = 1'b1;
    repeat (5) tick();
    din_vld_i = 1'b0;
    repeat (3) tick();
    #1 chk(ocnt == base, "R8", ocnt - base, 0);

    // R8: data strobe in the start cycle is not taken
    #1 base = ocnt;
    start_i = 1'b1; din_vld_i = 1'b1; din_i = 1'b1; tick();
    start_i = 1'b0; din_vld_i = 1'b0;
    send_msg(4'b0010, 1'b0);
    repeat (6) tick();
    #1 chk(ocnt == base + 7, "R8", ocnt - base, 7);
    check_frame(base, 4'b0010, "R8");

    // R7: start in mid-frame ignored
    #1 base = ocnt;
    start_frame();
    din_vld_i = 1'b1; din_i = 1'b1; tick();
    din_vld_i = 1'b1; din_i = 1'b0; tick();
    din_vld_i = 1'b0; start_i = 1'b1; tick(); start_i = 1'b0;
    din_vld_i = 1'b1; din_i = 1'b1; tick();
    din_vld_i = 1'b1; din_i = 1'b1; tick();
    din_vld_i = 1'b0;
    repeat (2) tick();
    start_i = 1'b1; tick();
    chk(dout_last_o == 1'b1, "R7", dout_last_o, 1);
    tick();
    start_i = 1'b0;
    send_msg(4'b0110, 1'b0);
    repeat (8) tick();
    #1 chk(ocnt == base + 14, "R7", ocnt - base, 14);
    check_frame(base, 4'b1011, "R7");
    check_frame(base + 7, 4'b0110, "R7");
    repeat (4) tick();
    #1 chk(ocnt == base + 14, "R10", ocnt - base, 14);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule